// File: doc/BRIEF.md
# Three-Level Mode Switch Decoder with Continuity Tone Generator

This block sits between the front-panel selector switches of a bench meter and its measurement sequencer. Each of the four selector inputs can be tied high, tied low, or left open. An analog front end outside this block turns each input into a 2-bit level code before it arrives here. The block turns these codes into the measurement kind (volts, amps or ohms), the two range-group selects, a display-freeze control and a test request.

The decoded settings are loaded only when the sequencer pulses `frame_tick` at a measurement frame boundary. A switch moved during a conversion therefore takes effect on the next frame and never during the current one.

The block also drives a piezo continuity beeper from the oscillator clock. The tone is a square wave with a period of `TONE_DIV` clocks, which gives 2 kHz from a 120 kHz oscillator with the default of 60. An external comparator reports a short across the unknown on `cont_raw`. That signal is synchronized first. The tone sounds only while the meter is in ohms mode on the low-resistance group. A small state machine starts and stops the tone only at half-period boundaries. Its states are IDLE (output resting high), LOW_HALF and HIGH_HALF, with these transitions:

- IDLE to LOW_HALF when the tone is enabled.
- LOW_HALF to HIGH_HALF after `TONE_DIV/2` clocks.
- HIGH_HALF to LOW_HALF after `TONE_DIV/2` clocks if the tone is still enabled.
- HIGH_HALF to IDLE after `TONE_DIV/2` clocks if the tone is no longer enabled.

The mode register is a second state machine with states VOLT, AMP and OHM. On a frame tick it moves to the state selected by the function input, and it holds its state otherwise.

Top module: `tern_mode_beeper`

## Requirements
- R1: On a frame tick the function input selects the measurement kind on `meas_mode`. High (code 2'b10) gives ohms (2'b10). Middle (code 2'b01) gives volts (2'b00). Low (code 2'b00) gives amps (2'b01).
- R2: On a frame tick `grp_milli` becomes 1 when the current input is high (2'b10). It becomes 0 when that input is middle or low.
- R3: On a frame tick `hi_ohm_dc` becomes 1 when the resistance/AC input is high (2'b10). It becomes 0 when that input is middle or low.
- R4: On a frame tick `hold_en` becomes 1 when the hold input is high (2'b10). It becomes 0 when that input is middle or low.
- R5: On a frame tick `test_req` becomes 1 if any of the current, resistance/AC or hold inputs is low (2'b00). Otherwise it becomes 0.
- R6: The reserved level code 2'b11 on any input decodes exactly as the middle level.
- R7: After reset, `meas_mode` is volts and `grp_milli`, `hi_ohm_dc`, `hold_en` and `test_req` are 0. All decoded outputs change only on the clock edge that samples `frame_tick` high, and they are visible from the following cycle.
- R8: While enabled, `beep_out` is a square wave with a period of `TONE_DIV` clocks. Each level lasts exactly `TONE_DIV/2` clocks.
- R9: The tone is enabled only while `meas_mode` is ohms, `hi_ohm_dc` is 0 and the synchronized continuity input is 1. `cont_raw` passes through `SYNC_STAGES` flops. The first low half therefore begins `SYNC_STAGES+1` edges after `cont_raw` rises.
- R10: `beep_out` is 1 during and after reset and at all times when the tone is idle.
- R11: The tone always starts with a full low half. If it is disabled mid-tone, it finishes the current low half and the following high half, then rests high. No level of the tone lasts less than `TONE_DIV/2` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe at a measurement frame boundary |
| func_lvl | input | 2 | Function switch level code |
| cur_lvl | input | 2 | Current-group switch level code |
| rng_lvl | input | 2 | Resistance/AC group switch level code |
| hold_lvl | input | 2 | Hold switch level code |
| cont_raw | input | 1 | Asynchronous continuity comparator output |
| meas_mode | output | 2 | Measurement kind: 00 volts, 01 amps, 10 ohms |
| grp_milli | output | 1 | 1 selects the milliamp current group |
| hi_ohm_dc | output | 1 | 1 selects the high-ohms / DC group |
| hold_en | output | 1 | 1 freezes the display reading |
| test_req | output | 1 | Test mode request |
| beep_out | output | 1 | Piezo drive, rests high |

## Verification
The bound checker watches several behaviours on every cycle:
- Decoded outputs stay frozen between frame ticks.
- A high function level yields ohms after a tick.
- A low level on any of the three group inputs raises the test request.
- Every low half of the tone lasts exactly `TONE_DIV/2` clocks.
- A tone only begins from an enabled condition.

Some properties cannot be seen one cycle at a time, and only the bench scenarios show them:
- The full period of the tone.
- The synchronizer latency from `cont_raw` to the first low half.
- The finish-the-cycle stop after the continuity input drops.
- Silence in high-ohms and volts modes.
- Treatment of the reserved code.
- Reset in the middle of a tone.

// File: rtl/tmb_pkg.sv
`timescale 1ns/1ps
package tmb_pkg;

    // Position of each selector inside the packed level-code bus
    localparam int N_SW     = 4;
    localparam int SW_FUNC  = 0;
    localparam int SW_CUR   = 1;
    localparam int SW_RNG   = 2;
    localparam int SW_HOLD  = 3;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_RSVD = 2'b11
    } lvl_code_t;

    typedef enum logic [1:0] {
        TL_LOW,
        TL_MID,
        TL_HIGH
    } tri_lvl_t;

    typedef enum logic [1:0] {
        MODE_VOLT = 2'b00,
        MODE_AMP  = 2'b01,
        MODE_OHM  = 2'b10
    } meas_mode_t;

    typedef enum logic [1:0] {
        BP_IDLE,
        BP_LOW,
        BP_HIGH
    } beep_state_t;

    typedef struct packed {
        meas_mode_t mode;
        logic       grp_milli;
        logic       hi_ohm_dc;
        logic       hold;
        logic       test;
    } panel_cfg_t;

    // Reserved code folds onto the middle level
    function automatic tri_lvl_t to_tri(input logic [1:0] code);
        case (code)
            LVL_LOW:  return TL_LOW;
            LVL_HIGH: return TL_HIGH;
            default:  return TL_MID;
        endcase
    endfunction

endpackage

// File: rtl/tmb_level_decode.sv
`timescale 1ns/1ps
module tmb_level_decode
    import tmb_pkg::*;
#(
    parameter int N_IN = N_SW
) (
    input  logic [2*N_IN-1:0] codes,
    output logic [N_IN-1:0]   is_low,
    output logic [N_IN-1:0]   is_high
);

    for (genvar g = 0; g < N_IN; g++) begin : g_sw
        tri_lvl_t lvl;
        assign lvl        = to_tri(codes[2*g +: 2]);
        assign is_low[g]  = (lvl == TL_LOW);
        assign is_high[g] = (lvl == TL_HIGH);
    end

endmodule

// File: rtl/tmb_sync.sv
`timescale 1ns/1ps
module tmb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    if (STAGES == 1) begin : g_one
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= d_async;
        end
    end else begin : g_multi
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/tmb_mode_fsm.sv
`timescale 1ns/1ps
module tmb_mode_fsm
    import tmb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_tick,
    input  logic [N_SW-1:0] is_low,
    input  logic [N_SW-1:0] is_high,
    output panel_cfg_t      cfg
);

    meas_mode_t mode_q, mode_d, mode_tgt;
    logic       milli_q, hiohm_q, hold_q, test_q;

    // Target kind requested by the function selector
    always_comb begin
        if (is_high[SW_FUNC])     mode_tgt = MODE_OHM;
        else if (is_low[SW_FUNC]) mode_tgt = MODE_AMP;
        else                      mode_tgt = MODE_VOLT;
    end

    // Next-state: move only at a frame boundary
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_VOLT: if (frame_tick) mode_d = mode_tgt;
            MODE_AMP:  if (frame_tick) mode_d = mode_tgt;
            MODE_OHM:  if (frame_tick) mode_d = mode_tgt;
            default:   mode_d = MODE_VOLT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_VOLT;
        else        mode_q <= mode_d;
    end

    // Group selects and controls, loaded with the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            milli_q <= 1'b0;
            hiohm_q <= 1'b0;
            hold_q  <= 1'b0;
            test_q  <= 1'b0;
        end else if (frame_tick) begin
            milli_q <= is_high[SW_CUR];
            hiohm_q <= is_high[SW_RNG];
            hold_q  <= is_high[SW_HOLD];
            test_q  <= is_low[SW_CUR] | is_low[SW_RNG] | is_low[SW_HOLD];
        end
    end

    assign cfg = '{mode: mode_q, grp_milli: milli_q, hi_ohm_dc: hiohm_q,
                   hold: hold_q, test: test_q};

endmodule

// File: rtl/tmb_beeper.sv
`timescale 1ns/1ps
module tmb_beeper
    import tmb_pkg::*;
#(
    parameter int TONE_DIV = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tone_en,
    output logic beep_out
);

    localparam int HALF = TONE_DIV / 2;
    localparam int CW   = $clog2(HALF + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    beep_state_t     state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            beep_q;

    // Next-state and half-period counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BP_IDLE: begin
                cnt_d = '0;
                if (tone_en) state_d = BP_LOW;
            end
            BP_LOW: begin
                if (cnt_q == LAST) begin
                    cnt_d   = '0;
                    state_d = BP_HIGH;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            BP_HIGH: begin
                if (cnt_q == LAST) begin
                    cnt_d   = '0;
                    state_d = tone_en ? BP_LOW : BP_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                cnt_d   = '0;
                state_d = BP_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BP_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output register: low only in the low half
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) beep_q <= 1'b1;
        else        beep_q <= (state_d != BP_LOW);
    end

    assign beep_out = beep_q;

endmodule

// File: rtl/tern_mode_beeper.sv
`timescale 1ns/1ps
module tern_mode_beeper
    import tmb_pkg::*;
#(
    parameter int TONE_DIV    = 60,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_tick,
    input  logic [1:0] func_lvl,
    input  logic [1:0] cur_lvl,
    input  logic [1:0] rng_lvl,
    input  logic [1:0] hold_lvl,
    input  logic       cont_raw,
    output logic [1:0] meas_mode,
    output logic       grp_milli,
    output logic       hi_ohm_dc,
    output logic       hold_en,
    output logic       test_req,
    output logic       beep_out
);

    logic [2*N_SW-1:0] codes;
    logic [N_SW-1:0]   is_low, is_high;
    panel_cfg_t        cfg;
    logic              cont_sync;
    logic              tone_en;

    assign codes = {hold_lvl, rng_lvl, cur_lvl, func_lvl};

    tmb_level_decode #(.N_IN(N_SW)) u_dec (
        .codes   (codes),
        .is_low  (is_low),
        .is_high (is_high)
    );

    tmb_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .is_low     (is_low),
        .is_high    (is_high),
        .cfg        (cfg)
    );

    tmb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cont_raw),
        .q_sync  (cont_sync)
    );

    assign tone_en = cont_sync && (cfg.mode == MODE_OHM) && !cfg.hi_ohm_dc;

    tmb_beeper #(.TONE_DIV(TONE_DIV)) u_beep (
        .clk      (clk),
        .rst_n    (rst_n),
        .tone_en  (tone_en),
        .beep_out (beep_out)
    );

    assign meas_mode = cfg.mode;
    assign grp_milli = cfg.grp_milli;
    assign hi_ohm_dc = cfg.hi_ohm_dc;
    assign hold_en   = cfg.hold;
    assign test_req  = cfg.test;

endmodule

// File: rtl/tern_mode_beeper_chk.sv
`timescale 1ns/1ps
module tern_mode_beeper_chk #(
    parameter int HALF = 30
) (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_tick,
    input logic [1:0] func_lvl,
    input logic [1:0] cur_lvl,
    input logic [1:0] rng_lvl,
    input logic [1:0] hold_lvl,
    input logic [1:0] meas_mode,
    input logic       grp_milli,
    input logic       hi_ohm_dc,
    input logic       hold_en,
    input logic       test_req,
    input logic       beep_out,
    input logic       cont_sync
);

    logic [15:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             low_run <= '0;
        else if (beep_out)      low_run <= '0;
        else if (low_run != '1) low_run <= low_run + 16'd1;
    end

    assert_ohm_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && func_lvl == 2'b10) |=> (meas_mode == 2'b10));

    assert_test_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && (cur_lvl == 2'b00 || rng_lvl == 2'b00 || hold_lvl == 2'b00))
        |=> test_req);

    assert_frame_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable({meas_mode, grp_milli, hi_ohm_dc, hold_en, test_req}));

    assert_start_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(beep_out) |-> $past(cont_sync && meas_mode == 2'b10 && !hi_ohm_dc));

    assert_full_low_half_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beep_out) |-> (low_run == 16'(HALF)));

endmodule

bind tern_mode_beeper tern_mode_beeper_chk #(.HALF(TONE_DIV / 2)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .func_lvl   (func_lvl),
    .cur_lvl    (cur_lvl),
    .rng_lvl    (rng_lvl),
    .hold_lvl   (hold_lvl),
    .meas_mode  (meas_mode),
    .grp_milli  (grp_milli),
    .hi_ohm_dc  (hi_ohm_dc),
    .hold_en    (hold_en),
    .test_req   (test_req),
    .beep_out   (beep_out),
    .cont_sync  (cont_sync)
);

// File: tb/tern_mode_beeper_test.sv
`timescale 1ns/1ps
module tern_mode_beeper_test;

    localparam int TONE_DIV = 60;
    localparam int HALF     = TONE_DIV / 2;
    localparam int SYNC     = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 1'b0;
    logic [1:0] func_lvl = 2'b01, cur_lvl = 2'b01, rng_lvl = 2'b01, hold_lvl = 2'b01;
    logic       cont_raw = 1'b0;
    logic [1:0] meas_mode;
    logic       grp_milli, hi_ohm_dc, hold_en, test_req, beep_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tern_mode_beeper #(.TONE_DIV(TONE_DIV), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .func_lvl(func_lvl), .cur_lvl(cur_lvl), .rng_lvl(rng_lvl), .hold_lvl(hold_lvl),
        .cont_raw(cont_raw), .meas_mode(meas_mode), .grp_milli(grp_milli),
        .hi_ohm_dc(hi_ohm_dc), .hold_en(hold_en), .test_req(test_req), .beep_out(beep_out)
    );

    // ---------------- behavioural reference model ----------------
    int sync_q[$];
    int m_mode = 0, m_milli = 0, m_hi = 0, m_hold = 0, m_test = 0;
    int m_phase = 0;      // 0 silent, 1 low half, 2 high half
    int m_left = 0;       // cycles remaining in the current half
    int m_beep = 1;

    function automatic int lvl3(input logic [1:0] c);
        if (c == 2'b00) return 0;
        if (c == 2'b10) return 2;
        return 1;
    endfunction

    initial for (int k = 0; k < SYNC; k++) sync_q.push_back(0);

    always @(posedge clk) begin
        if (!rst_n) begin
            sync_q = {};
            for (int k = 0; k < SYNC; k++) sync_q.push_back(0);
            m_mode = 0; m_milli = 0; m_hi = 0; m_hold = 0; m_test = 0;
            m_phase = 0; m_left = 0; m_beep = 1;
        end else begin
            int synced;
            bit en;
            synced = sync_q[SYNC-1];
            en = (synced == 1) && (m_mode == 2) && (m_hi == 0);
            if (m_phase == 0) begin
                if (en) begin m_phase = 1; m_left = HALF; end
            end else begin
                m_left--;
                if (m_left == 0) begin
                    if (m_phase == 1) begin m_phase = 2; m_left = HALF; end
                    else if (en)      begin m_phase = 1; m_left = HALF; end
                    else              m_phase = 0;
                end
            end
            m_beep = (m_phase == 1) ? 0 : 1;
            void'(sync_q.pop_back());
            sync_q.push_front(int'(cont_raw));
            if (frame_tick) begin
                case (lvl3(func_lvl))
                    0: m_mode = 1;
                    2: m_mode = 2;
                    default: m_mode = 0;
                endcase
                m_milli = (lvl3(cur_lvl) == 2);
                m_hi    = (lvl3(rng_lvl) == 2);
                m_hold  = (lvl3(hold_lvl) == 2);
                m_test  = (lvl3(cur_lvl) == 0) || (lvl3(rng_lvl) == 0) || (lvl3(hold_lvl) == 0);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        int got, exp;
        @(negedge clk);
        got = {meas_mode, grp_milli, hi_ohm_dc, hold_en, test_req, beep_out};
        exp = (m_mode << 5) | (m_milli << 4) | (m_hi << 3) | (m_hold << 2) | (m_test << 1) | m_beep;
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL model compare R7/R8/R9/R11 at %0t: actual %b expected %b",
                     $time, got[5:0], exp[5:0]);
        end
    endtask

    task automatic tick_frame();
        frame_tick = 1'b1;
        step();
        frame_tick = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        int lows, first_fall, last_fall, falls, run;
        repeat (3) step();
        chk("R7 reset mode", meas_mode, 0);
        chk("R7 reset test", test_req, 0);
        chk("R10 reset beep", beep_out, 1);
        rst_n = 1'b1;
        step();

        func_lvl = 2'b10;
        repeat (4) step();
        chk("R7 no tick no change", meas_mode, 0);
        tick_frame(); chk("R1 ohms", meas_mode, 2);
        func_lvl = 2'b00; tick_frame(); chk("R1 amps", meas_mode, 1);
        func_lvl = 2'b01; tick_frame(); chk("R1 volts", meas_mode, 0);
        func_lvl = 2'b11; tick_frame(); chk("R6 func reserved", meas_mode, 0);

        func_lvl = 2'b10;
        cur_lvl = 2'b10; tick_frame(); chk("R2 milli", grp_milli, 1); chk("R5 no test", test_req, 0);
        cur_lvl = 2'b00; tick_frame(); chk("R5 cur low", test_req, 1); chk("R2 low gives 0", grp_milli, 0);
        cur_lvl = 2'b01;
        rng_lvl = 2'b10; tick_frame(); chk("R3 hi ohm", hi_ohm_dc, 1);
        rng_lvl = 2'b00; tick_frame(); chk("R5 rng low", test_req, 1); chk("R3 low gives 0", hi_ohm_dc, 0);
        rng_lvl = 2'b11; tick_frame(); chk("R6 rng reserved", hi_ohm_dc, 0); chk("R6 no test", test_req, 0);
        hold_lvl = 2'b10; tick_frame(); chk("R4 hold", hold_en, 1);
        hold_lvl = 2'b00; tick_frame(); chk("R5 hold low", test_req, 1); chk("R4 low gives 0", hold_en, 0);
        hold_lvl = 2'b11; tick_frame(); chk("R6 hold reserved", hold_en, 0);
        hold_lvl = 2'b01;

        // ohms, low-resistance group: silent without continuity
        lows = 0;
        repeat (10) begin step(); if (!beep_out) lows++; end
        chk("R10 idle high", lows, 0);

        // tone period and latency
        cont_raw = 1'b1;
        first_fall = -1; last_fall = -1; falls = 0;
        for (int i = 0; i < 300; i++) begin
            logic prev;
            prev = beep_out;
            step();
            if (prev && !beep_out) begin
                if (first_fall < 0) first_fall = i;
                else chk("R8 period", i - last_fall, TONE_DIV);
                last_fall = i;
                falls++;
            end
            if (!prev && beep_out) chk("R8 low half", i - last_fall, HALF);
        end
        chk("R9 sync latency", first_fall, SYNC);
        chk("R8 cycle count", falls, 5);

        // drop continuity a few cycles into a low half
        run = 0;
        while (beep_out && run < 100) begin step(); run++; end
        repeat (5) step();
        cont_raw = 1'b0;
        run = 6;
        while (!beep_out && run < 100) begin step(); if (!beep_out) run++; end
        chk("R11 low half completes", run, HALF);
        lows = 0;
        repeat (100) begin step(); if (!beep_out) lows++; end
        chk("R11 rests high after stop", lows, 0);

        // high-ohms group: silent
        rng_lvl = 2'b10; tick_frame();
        cont_raw = 1'b1;
        lows = 0;
        repeat (100) begin step(); if (!beep_out) lows++; end
        chk("R9 silent in high ohms", lows, 0);

        // volts mode: silent
        rng_lvl = 2'b01; func_lvl = 2'b01; tick_frame();
        lows = 0;
        repeat (100) begin step(); if (!beep_out) lows++; end
        chk("R9 silent in volts", lows, 0);

        // back to low ohms: tone resumes
        func_lvl = 2'b10; tick_frame();
        lows = 0;
        repeat (10) begin step(); if (!beep_out) lows++; end
        chk("R9 tone resumes", (lows > 0) ? 1 : 0, 1);

        // reset during tone
        rst_n = 1'b0;
        step();
        chk("R10 reset mid tone", beep_out, 1);
        chk("R7 reset mode", meas_mode, 0);
        rst_n = 1'b1;
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule